// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core. Every rising clock edge retires exactly one instruction. It supports a compact integer subset:

- register-register arithmetic, logic and signed compare;
- immediate forms of the same operations;
- word loads and stores;
- two conditional branches on register equality;
- an absolute jump.

Program fetch reads a private instruction array, and loads and stores use a separate data array. Both arrays hold 256 words.

Before the core runs, a host writes the program into the instruction array through a load port while reset is held. After reset is released, the core executes from address 0. It exposes two things for observation: its program counter, and a combinational read port into the register file. Together these let a host inspect the architectural state at any time.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o` reads 0 and every register reads 0 on the debug port.
- R2: Encodings follow these layouts:
  - R-type: op[31:26] = 0, rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]. Funct values are add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26, slt 0x2A. An R-type word with nonzero shamt is not executed.
  - I-type: op, rs, rt, imm16[15:0]. Opcodes are addi 0x08, slti 0x0A, andi 0x0C, ori 0x0D, xori 0x0E, lw 0x23, sw 0x2B, beq 0x04, bne 0x05.
  - J-type: op 0x02 with imm26[25:0].
- R3: R-type operations write rd with rs op rt. slt yields 1 when rs < rt as signed values, else 0.
- R4: Immediate operations write rt. addi and slti sign-extend imm16. andi, ori and xori zero-extend imm16.
- R5: lw and sw use byte address rs + sign-extended imm16, on word index address[9:2]. lw writes the loaded word to rt, and sw stores rt.
  - An address with bits [31:10] nonzero or bits [1:0] nonzero is outside the array.
  - A store to such an address is dropped, and a load from it returns 0.
- R6: sw, beq, bne and j write no register. Any word that is not a listed encoding writes no register and no memory, and only advances the PC by 4.
- R7: When no branch or jump is taken, the next PC is PC + 4.
- R8: Branch and jump targets are computed as follows:
  - beq is taken when rs equals rt, and bne is taken when they differ. A taken branch loads PC + 4 + (sign-extended imm16 << 2).
  - j loads {PC[31:28], imm26, 2'b00}.
- R9: Register 0 always reads 0 and ignores writes. Other registers update on the clock edge that retires the writing instruction. Reads, including the debug port, are combinational.
- R10: With `imem_we_i` high at a rising edge, `imem_wdata_i` is stored at word index `imem_addr_i`. A fetch from a PC whose bits [31:10] are nonzero returns 0, which is an undefined R-type word (see R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_we_i | input | 1 | Instruction array write enable |
| imem_addr_i | input | 8 | Instruction array word index |
| imem_wdata_i | input | 32 | Instruction word to store |
| dbg_reg_addr_i | input | 5 | Register number for debug read |
| dbg_reg_data_o | output | 32 | Current value of the selected register |
| pc_o | output | 32 | Address of the instruction being executed |

## Verification
The hardest case to reach from the ports is a taken conditional branch whose comparison depends on a value the core itself just loaded from the data array. Only a preceding store-then-load chain builds that operand. The program therefore stores a word, reloads it, and branches on its equality with the original register. It also places instructions that must never execute in the shadow of each taken branch and of the jump, and ends in a backward self-branch. A behavioural model in the bench steps alongside the core every cycle. It compares the PC and a rotating register. Afterwards a directed pass reads every register the program touches.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    reg_dst_rd;
    logic    ext_sign;
    logic    src_imm;
    logic    mem_rd;
    logic    mem_we;
    logic    wb_mem;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [4:0] shamt_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (op_i)
      OP_RTYPE: begin
        if (shamt_i == '0) begin
          ctrl_o.reg_we     = 1'b1;
          ctrl_o.reg_dst_rd = 1'b1;
          case (funct_i)
            FN_ADD:  ctrl_o.alu_op = ALU_ADD;
            FN_SUB:  ctrl_o.alu_op = ALU_SUB;
            FN_AND:  ctrl_o.alu_op = ALU_AND;
            FN_OR:   ctrl_o.alu_op = ALU_OR;
            FN_XOR:  ctrl_o.alu_op = ALU_XOR;
            FN_SLT:  ctrl_o.alu_op = ALU_SLT;
            default: ctrl_o.reg_we = 1'b0;
          endcase
        end
      end
      OP_ADDI: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.src_imm = 1'b1; ctrl_o.ext_sign = 1'b1;
      end
      OP_SLTI: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.src_imm = 1'b1; ctrl_o.ext_sign = 1'b1;
        ctrl_o.alu_op = ALU_SLT;
      end
      OP_ANDI: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.src_imm = 1'b1; ctrl_o.alu_op = ALU_AND;
      end
      OP_ORI: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.src_imm = 1'b1; ctrl_o.alu_op = ALU_OR;
      end
      OP_XORI: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.src_imm = 1'b1; ctrl_o.alu_op = ALU_XOR;
      end
      OP_LW: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.src_imm = 1'b1; ctrl_o.ext_sign = 1'b1;
        ctrl_o.mem_rd = 1'b1; ctrl_o.wb_mem = 1'b1;
      end
      OP_SW: begin
        ctrl_o.src_imm = 1'b1; ctrl_o.ext_sign = 1'b1; ctrl_o.mem_we = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.br_eq = 1'b1; ctrl_o.alu_op = ALU_SUB;
      end
      OP_BNE: begin
        ctrl_o.br_ne = 1'b1; ctrl_o.alu_op = ALU_SUB;
      end
      OP_J:    ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = '0;
    endcase
  end
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  parameter int NRD  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0][$clog2(NREG)-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]      rdata_o,
  input  logic                       we_i,
  input  logic [$clog2(NREG)-1:0]    waddr_i,
  input  logic [W-1:0]               wdata_i
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = regs_q[raddr_i[p]];
  end

  // R9
  rf_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != AW'(0)) |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               imem_we_i,
  input  logic [IMEM_AW-1:0] imem_addr_i,
  input  logic [XLEN-1:0]    imem_wdata_i,
  input  logic [4:0]         dbg_reg_addr_i,
  output logic [XLEN-1:0]    dbg_reg_data_o,
  output logic [XLEN-1:0]    pc_o
);
  localparam int PCW        = XLEN - 2;
  localparam int IMEM_DEPTH = 1 << IMEM_AW;
  localparam int DMEM_DEPTH = 1 << DMEM_AW;

  // fetch
  logic [PCW-1:0]  pc_q, pc_inc, pc_br, pc_jmp, pc_nxt;
  logic [XLEN-1:0] imem_q [IMEM_DEPTH];
  logic [XLEN-1:0] instr;
  logic            imem_hit;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem_q[imem_addr_i] <= imem_wdata_i;
  end

  assign imem_hit = (pc_q[PCW-1:IMEM_AW] == '0);
  assign instr    = imem_hit ? imem_q[pc_q[IMEM_AW-1:0]] : '0;

  // decode
  ctrl_t ctrl;
  sc_decode i_decode (
    .op_i    (instr[31:26]),
    .shamt_i (instr[10:6]),
    .funct_i (instr[5:0]),
    .ctrl_o  (ctrl)
  );

  // register file: port 0 rs, port 1 rt, port 2 debug
  logic [2:0][4:0]      rf_raddr;
  logic [2:0][XLEN-1:0] rf_rdata;
  logic [XLEN-1:0]      rs_data, rt_data, wb_data;
  logic [4:0]           wb_addr;

  assign rf_raddr = {dbg_reg_addr_i, instr[20:16], instr[25:21]};
  assign rs_data  = rf_rdata[0];
  assign rt_data  = rf_rdata[1];
  assign wb_addr  = ctrl.reg_dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .NREG(32), .NRD(3)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata),
    .we_i    (ctrl.reg_we),
    .waddr_i (wb_addr),
    .wdata_i (wb_data)
  );

  // execute
  logic [XLEN-1:0] imm_ext, alu_b, alu_res;
  logic            alu_zero;

  assign imm_ext = ctrl.ext_sign ? {{(XLEN-16){instr[15]}}, instr[15:0]}
                                 : {{(XLEN-16){1'b0}}, instr[15:0]};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

  sc_alu #(.W(XLEN)) i_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  // data memory: word aligned, in range only
  logic [XLEN-1:0]    dmem_q [DMEM_DEPTH];
  logic [DMEM_AW-1:0] dmem_idx;
  logic [XLEN-1:0]    dmem_rdata;
  logic               dmem_hit, dmem_we;

  assign dmem_hit   = (alu_res[XLEN-1:DMEM_AW+2] == '0) && (alu_res[1:0] == 2'b00);
  assign dmem_idx   = alu_res[DMEM_AW+1:2];
  assign dmem_we    = ctrl.mem_we && dmem_hit;
  assign dmem_rdata = (ctrl.mem_rd && dmem_hit) ? dmem_q[dmem_idx] : '0;

  always_ff @(posedge clk_i) begin
    if (dmem_we) dmem_q[dmem_idx] <= rt_data;
  end

  assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_res;

  // next PC
  logic pc_sel;
  assign pc_inc = pc_q + PCW'(1);
  assign pc_br  = pc_inc + {{(PCW-16){instr[15]}}, instr[15:0]};
  assign pc_jmp = {pc_q[PCW-1:PCW-4], instr[25:0]};
  assign pc_sel = ctrl.jump | (ctrl.br_eq & alu_zero) | (ctrl.br_ne & ~alu_zero);
  assign pc_nxt = pc_sel ? (ctrl.jump ? pc_jmp : pc_br) : pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  assign pc_o           = {pc_q, 2'b00};
  assign dbg_reg_data_o = rf_rdata[2];

  // R7
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl.jump || ctrl.br_eq || ctrl.br_ne) |=> pc_q == $past(pc_q) + PCW'(1));

  // R8
  jump_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.jump |=> pc_q == {$past(pc_q[PCW-1:PCW-4]), $past(instr[25:0])});

  // R8
  beq_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.br_eq && rs_data == rt_data) |=>
      pc_q == $past(pc_q + PCW'(1) + {{(PCW-16){instr[15]}}, instr[15:0]}));

  // R8
  bne_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.br_ne && rs_data == rt_data) |=> pc_q == $past(pc_q) + PCW'(1));

  // R6
  store_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we |-> (instr[31:26] == OP_SW && !ctrl.reg_we));
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [7:0]  imem_addr = '0;
  logic [31:0] imem_wdata = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data, pc;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core i_sc_core (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .imem_we_i      (imem_we),
    .imem_addr_i    (imem_addr),
    .imem_wdata_i   (imem_wdata),
    .dbg_reg_addr_i (dbg_addr),
    .dbg_reg_data_o (dbg_data),
    .pc_o           (pc)
  );

  // reference model state
  logic [31:0] m_im [256];
  logic [31:0] m_dm [256];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;
  string       m_tag;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic m_wr(logic [4:0] idx, logic [31:0] v);
    if (idx != 0) m_rf[idx] = v;
  endtask

  task automatic m_step();
    logic [31:0] w, a, b, sx, zx, addr, nxt;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    w  = (m_pc[31:10] == 0) ? m_im[m_pc[9:2]] : 32'h0;
    op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; sh = w[10:6]; fn = w[5:0];
    a  = m_rf[rs]; b = m_rf[rt];
    sx = {{16{w[15]}}, w[15:0]};
    zx = {16'h0, w[15:0]};
    nxt = m_pc + 4;
    m_tag = "R7";
    case (op)
      6'h00: if (sh == 0) begin
        case (fn)
          6'h20: m_wr(rd, a + b);
          6'h22: m_wr(rd, a - b);
          6'h24: m_wr(rd, a & b);
          6'h25: m_wr(rd, a | b);
          6'h26: m_wr(rd, a ^ b);
          6'h2A: m_wr(rd, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
          default: ;
        endcase
      end
      6'h08: m_wr(rt, a + sx);
      6'h0A: m_wr(rt, ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0);
      6'h0C: m_wr(rt, a & zx);
      6'h0D: m_wr(rt, a | zx);
      6'h0E: m_wr(rt, a ^ zx);
      6'h23: begin
        addr = a + sx;
        m_wr(rt, (addr[31:10] == 0 && addr[1:0] == 0) ? m_dm[addr[9:2]] : 32'h0);
      end
      6'h2B: begin
        addr = a + sx;
        if (addr[31:10] == 0 && addr[1:0] == 0) m_dm[addr[9:2]] = b;
      end
      6'h04: begin m_tag = "R8"; if (a == b) nxt = m_pc + 4 + (sx << 2); end
      6'h05: begin m_tag = "R8"; if (a != b) nxt = m_pc + 4 + (sx << 2); end
      6'h02: begin m_tag = "R8"; nxt = {m_pc[31:28], w[25:0], 2'b00}; end
      default: ;
    endcase
    m_pc = nxt;
  endtask

  always @(posedge clk) if (rst_n) m_step();

  logic [31:0] prog [30];
  initial begin
    prog[0]  = enc_i(6'h08, 0, 1, 16'hFFFB);    // addi r1,r0,-5
    prog[1]  = enc_i(6'h0D, 0, 2, 16'h8001);    // ori
    prog[2]  = enc_i(6'h0C, 1, 3, 16'hF0F0);    // andi
    prog[3]  = enc_i(6'h0E, 2, 4, 16'hFFFF);    // xori
    prog[4]  = enc_r(1, 2, 5, 0, 6'h20);        // add
    prog[5]  = enc_r(2, 1, 6, 0, 6'h22);        // sub
    prog[6]  = enc_r(1, 2, 7, 0, 6'h24);        // and
    prog[7]  = enc_r(1, 2, 8, 0, 6'h25);        // or
    prog[8]  = enc_r(1, 2, 9, 0, 6'h26);        // xor
    prog[9]  = enc_r(1, 2, 10, 0, 6'h2A);       // slt
    prog[10] = enc_i(6'h0A, 2, 11, 16'hFFFF);   // slti
    prog[11] = enc_i(6'h2B, 0, 2, 16'h0008);    // sw r2,8(r0)
    prog[12] = enc_i(6'h23, 0, 12, 16'h0008);   // lw r12
    prog[13] = enc_i(6'h08, 0, 13, 16'h0040);
    prog[14] = enc_i(6'h2B, 13, 1, 16'hFFFC);   // sw r1,-4(r13)
    prog[15] = enc_i(6'h23, 0, 14, 16'h003C);
    prog[16] = enc_i(6'h08, 0, 0, 16'h0007);    // write to r0
    prog[17] = enc_i(6'h04, 1, 2, 16'h0005);    // beq not taken
    prog[18] = enc_i(6'h05, 1, 2, 16'h0002);    // bne taken -> 21
    prog[19] = enc_i(6'h08, 0, 16, 16'h0001);
    prog[20] = enc_i(6'h08, 0, 16, 16'h0002);
    prog[21] = enc_i(6'h04, 12, 2, 16'h0001);   // beq on loaded value -> 23
    prog[22] = enc_i(6'h08, 0, 17, 16'h0009);
    prog[23] = enc_r(1, 2, 19, 0, 6'h3F);       // unknown funct
    prog[24] = enc_r(1, 2, 20, 1, 6'h20);       // nonzero shamt
    prog[25] = {6'h3F, 26'h0000123};            // unknown opcode
    prog[26] = enc_j(26'd28);
    prog[27] = enc_i(6'h08, 0, 18, 16'h0003);
    prog[28] = enc_i(6'h23, 0, 21, 16'h0400);   // lw out of range
    prog[29] = enc_i(6'h04, 0, 0, 16'hFFFF);    // self loop
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_im[i] = '0; m_dm[i] = '0; end
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    m_pc = '0;
    // R10: load program through the port while in reset
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 8'(i); imem_wdata = prog[i];
      m_im[i] = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    dbg_addr = 5'd7;
    #1;
    check("R1", "pc in reset", pc, 32'h0);
    check("R1", "reg7 in reset", dbg_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // lockstep compare
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      dbg_addr = 5'(c);
      #1;
      check(m_tag, "pc", pc, m_pc);
      check("R9", $sformatf("reg%0d", c % 32), dbg_data, m_rf[c % 32]);
    end
    // directed final state
    begin
      logic [31:0] exp [22];
      string       tag [22];
      exp[0]  = 32'h0;        tag[0]  = "R9";
      exp[1]  = 32'hFFFFFFFB; tag[1]  = "R4";
      exp[2]  = 32'h00008001; tag[2]  = "R4";
      exp[3]  = 32'h0000F0F0; tag[3]  = "R4";
      exp[4]  = 32'h00007FFE; tag[4]  = "R4";
      exp[5]  = 32'h00007FFC; tag[5]  = "R3";
      exp[6]  = 32'h00008006; tag[6]  = "R3";
      exp[7]  = 32'h00008001; tag[7]  = "R3";
      exp[8]  = 32'hFFFFFFFB; tag[8]  = "R3";
      exp[9]  = 32'hFFFF7FFA; tag[9]  = "R3";
      exp[10] = 32'h1;        tag[10] = "R3";
      exp[11] = 32'h0;        tag[11] = "R4";
      exp[12] = 32'h00008001; tag[12] = "R5";
      exp[13] = 32'h00000040; tag[13] = "R4";
      exp[14] = 32'hFFFFFFFB; tag[14] = "R5";
      exp[15] = 32'h0;        tag[15] = "R6";
      exp[16] = 32'h0;        tag[16] = "R8";
      exp[17] = 32'h0;        tag[17] = "R8";
      exp[18] = 32'h0;        tag[18] = "R8";
      exp[19] = 32'h0;        tag[19] = "R6";
      exp[20] = 32'h0;        tag[20] = "R2";
      exp[21] = 32'h0;        tag[21] = "R5";
      for (int r = 0; r < 22; r++) begin
        @(negedge clk);
        dbg_addr = 5'(r);
        #1;
        check(tag[r], $sformatf("final reg%0d", r), dbg_data, exp[r]);
      end
      check("R8", "final pc self loop", pc, 32'h74);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule